// File: doc/BRIEF.md
# Iterative Shift-and-Add Unsigned Multiplier with Short-Operand Early-Out

This block multiplies two unsigned words over many clock cycles. It uses one adder, which it reuses once per cycle. The result is a double-width product, returned as an upper word and a lower word. A flag reports whether the upper word is zero. A caller can treat a cleared flag as an overflow of the single-word result.

Each cycle runs one multiply step. The step adds the multiplicand into a partial-product register when the current low bit of the multiplier shift register is set. The partial-product/multiplier register pair then shifts right by one bit. The bit shifted into the top of the partial product is the exclusive-OR of the previous step's negative and overflow bits. This makes the engine signed-style, so a full-length run ends with a fix-up that adds the multiplier into the upper word when the multiplicand's top bit is set.

When both operands fit in `SHORT_BITS` bits, the block runs a shortened sequence and then realigns the product. The check is made on the OR of the two operands. When they do not fit, it runs the full sequence.

Top module: `iter_mul`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0, `prod_hi_o` and `prod_lo_o` are 0, and `hi_zero_o` is 1.
- R2: When bits `SHORT_BITS` and above of `mplier_i | mcand_i` are all zero at an accepted start, the block runs `SHORT_BITS` add-steps plus one shift-only step. `done_o` goes high 14 clock edges after the accepting edge (defaults). `busy_o` is high from the cycle after acceptance until the cycle before `done_o` rises.
- R3: Otherwise the block runs `WIDTH` add-steps plus one shift-only step. `done_o` goes high 34 clock edges after the accepting edge (defaults), with `busy_o` high in the same way as in R2.
- R4: When `done_o` is high, `{prod_hi_o, prod_lo_o}` equals the full unsigned product of the operands accepted at start. This includes operands whose top bit is set.
- R5: On a short run, `prod_hi_o` is 0 and `prod_lo_o` holds the whole product.
- R6: `hi_zero_o` is 1 exactly when `prod_hi_o` is zero. It updates together with the product.
- R7: `done_o` is high for exactly one cycle per operation. The product outputs hold their value until the next completion.
- R8: `start` is ignored while `busy_o` is high. Operands presented with such a start do not change the result in progress.
- R9: A `start` presented in the cycle where `done_o` is high is accepted, and a new operation begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a multiply; sampled when not busy |
| mplier_i | input | WIDTH | Multiplier operand |
| mcand_i | input | WIDTH | Multiplicand operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: product outputs valid |
| prod_hi_o | output | WIDTH | Upper word of product |
| prod_lo_o | output | WIDTH | Lower word of product |
| hi_zero_o | output | 1 | Upper word is zero |

## Verification
The completion pulse of one operation and the acceptance of the next can fall in the same cycle. The bench provokes this by holding `start` high with fresh operands through the `done_o` cycle. The reference model then expects a new run whose timing follows the new operands' length class, while the finished product is still on the outputs. A second overlap occurs when `start` is raised mid-run with different operands. The model expects both the timing and the finished product to stay unchanged. Both cases are judged on every clock against a behavioural double-width product.

// File: rtl/imul_pkg.sv
package imul_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_STEP = 2'd1,
      ST_FIN  = 2'd2
   } imul_state_e;
endpackage

// File: rtl/imul_step.sv
// One multiply step: shift the partial/low pair right and conditionally add.
module imul_step #(
   parameter int W = 32
) (
   input  logic [W-1:0] part_i,
   input  logic [W-1:0] low_i,
   input  logic [W-1:0] mcand_i,
   input  logic         add_en_i,
   input  logic         neg_i,
   input  logic         ovf_i,
   output logic [W-1:0] part_o,
   output logic [W-1:0] low_o,
   output logic         neg_o,
   output logic         ovf_o
);
   logic [W-1:0] shifted;
   logic [W-1:0] addend;
   logic [W-1:0] sum;

   always_comb begin
      shifted = {neg_i ^ ovf_i, part_i[W-1:1]};
      addend  = (add_en_i && low_i[0]) ? mcand_i : '0;
      sum     = shifted + addend;
      part_o  = sum;
      low_o   = {part_i[0], low_i[W-1:1]};
      neg_o   = sum[W-1];
      ovf_o   = (shifted[W-1] == addend[W-1]) && (sum[W-1] != shifted[W-1]);
   end
endmodule

// File: rtl/imul_ctrl.sv
// Sequencer: counts add-steps, marks the shift-only step, then a finish cycle.
module imul_ctrl
   import imul_pkg::*;
#(
   parameter int LONG_STEPS  = 32,
   parameter int SHORT_STEPS = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic short_sel_i,
   output logic accept_o,
   output logic step_o,
   output logic last_o,
   output logic fin_o,
   output logic short_o,
   output logic busy_o
);
   localparam int CW = $clog2(LONG_STEPS + 2);

   imul_state_e     state_q;
   logic [CW-1:0]   cnt_q;
   logic [CW-1:0]   limit;
   logic            short_q;

   assign limit    = short_q ? CW'(SHORT_STEPS) : CW'(LONG_STEPS);
   assign accept_o = (state_q == ST_IDLE) && start_i;
   assign step_o   = (state_q == ST_STEP);
   assign last_o   = step_o && (cnt_q == limit);
   assign fin_o    = (state_q == ST_FIN);
   assign short_o  = short_q;
   assign busy_o   = (state_q != ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         short_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               state_q <= ST_STEP;
               cnt_q   <= '0;
               short_q <= short_sel_i;
            end
            ST_STEP: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == limit) state_q <= ST_FIN;
            end
            ST_FIN:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R2 / R3: the step counter never runs past the long limit
   a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      step_o |-> (cnt_q <= CW'(LONG_STEPS)));
   // R2: a short run never passes its own limit
   a_r2_short_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (step_o && short_q) |-> (cnt_q <= CW'(SHORT_STEPS)));
   // R8: while stepping, a start does not restart the count
   a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (step_o && !last_o) |=> (step_o && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/imul_result.sv
// Forms the final words from the partial and low registers.
module imul_result #(
   parameter int W          = 32,
   parameter int SHORT_BITS = 12
) (
   input  logic [W-1:0] part_i,
   input  logic [W-1:0] low_i,
   input  logic [W-1:0] mplier_i,
   input  logic [W-1:0] mcand_i,
   input  logic         short_i,
   output logic [W-1:0] hi_o,
   output logic [W-1:0] lo_o
);
   localparam int LOW_SH = W - SHORT_BITS;

   logic [W-1:0] fix_hi;
   logic [W-1:0] short_lo;

   assign fix_hi   = part_i + (mcand_i[W-1] ? mplier_i : '0);
   assign short_lo = (part_i << SHORT_BITS) | (low_i >> LOW_SH);

   always_comb begin
      if (short_i) begin
         hi_o = '0;
         lo_o = short_lo;
      end else begin
         hi_o = fix_hi;
         lo_o = low_i;
      end
   end
endmodule

// File: rtl/iter_mul.sv
module iter_mul
   import imul_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter int SHORT_BITS = 12,
   parameter bit SHORT_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] mplier_i,
   input  logic [WIDTH-1:0] mcand_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [WIDTH-1:0] prod_hi_o,
   output logic [WIDTH-1:0] prod_lo_o,
   output logic             hi_zero_o
);
   localparam int HIGH_BITS = WIDTH - SHORT_BITS;

   generate
      if (WIDTH < 4)
         $error("iter_mul: WIDTH must be at least 4");
      if (SHORT_BITS < 1 || 2 * SHORT_BITS > WIDTH)
         $error("iter_mul: SHORT_BITS must satisfy 1 <= 2*SHORT_BITS <= WIDTH");
   endgenerate

   logic [WIDTH-1:0] part_q, low_q, mplier_q, mcand_q;
   logic             neg_q, ovf_q;
   logic [WIDTH-1:0] part_nx, low_nx;
   logic             neg_nx, ovf_nx;
   logic             accept, step, last, fin, short_run, short_sel;
   logic [WIDTH-1:0] hi_nx, lo_nx;

   generate
      if (SHORT_EN) begin : g_short
         logic [HIGH_BITS-1:0] upper_or;
         assign upper_or  = mplier_i[WIDTH-1:SHORT_BITS] | mcand_i[WIDTH-1:SHORT_BITS];
         assign short_sel = (upper_or == '0);
      end else begin : g_noshort
         assign short_sel = 1'b0;
      end
   endgenerate

   imul_ctrl #(
      .LONG_STEPS  (WIDTH),
      .SHORT_STEPS (SHORT_BITS)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .short_sel_i (short_sel),
      .accept_o    (accept),
      .step_o      (step),
      .last_o      (last),
      .fin_o       (fin),
      .short_o     (short_run),
      .busy_o      (busy_o)
   );

   imul_step #(.W(WIDTH)) u_step (
      .part_i   (part_q),
      .low_i    (low_q),
      .mcand_i  (mcand_q),
      .add_en_i (!last),
      .neg_i    (neg_q),
      .ovf_i    (ovf_q),
      .part_o   (part_nx),
      .low_o    (low_nx),
      .neg_o    (neg_nx),
      .ovf_o    (ovf_nx)
   );

   imul_result #(.W(WIDTH), .SHORT_BITS(SHORT_BITS)) u_result (
      .part_i   (part_q),
      .low_i    (low_q),
      .mplier_i (mplier_q),
      .mcand_i  (mcand_q),
      .short_i  (short_run),
      .hi_o     (hi_nx),
      .lo_o     (lo_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         part_q   <= '0;
         low_q    <= '0;
         mplier_q <= '0;
         mcand_q  <= '0;
         neg_q    <= 1'b0;
         ovf_q    <= 1'b0;
      end else if (accept) begin
         part_q   <= '0;
         low_q    <= mplier_i;
         mplier_q <= mplier_i;
         mcand_q  <= mcand_i;
         neg_q    <= 1'b0;
         ovf_q    <= 1'b0;
      end else if (step) begin
         part_q <= part_nx;
         low_q  <= low_nx;
         neg_q  <= neg_nx;
         ovf_q  <= ovf_nx;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_o    <= 1'b0;
         prod_hi_o <= '0;
         prod_lo_o <= '0;
         hi_zero_o <= 1'b1;
      end else begin
         done_o <= fin;
         if (fin) begin
            prod_hi_o <= hi_nx;
            prod_lo_o <= lo_nx;
            hi_zero_o <= (hi_nx == '0);
         end
      end
   end

   // R7: completion is a single-cycle pulse
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R7: product holds between completions
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !fin |=> ($stable(prod_hi_o) && $stable(prod_lo_o)));
   // R8: operands are frozen while a run is in progress
   a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !fin) |=> ($stable(mcand_q) && $stable(mplier_q)));
   // R5: a short run finishes with an empty upper word
   a_r5_short_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && short_run) |=> (prod_hi_o == '0 && hi_zero_o));
   // R6: flag agrees with the upper word at completion
   a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (hi_zero_o == (prod_hi_o == '0)));
   // R2: no completion while idle-to-busy transition is in flight
   a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
endmodule

// File: tb/iter_mul_bench.sv
module iter_mul_bench;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] mplier = '0;
   logic [W-1:0] mcand = '0;
   logic         busy, done, hi_zero;
   logic [W-1:0] prod_hi, prod_lo;

   int total = 0;
   int bad   = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   iter_mul u_iter_mul (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .mplier_i  (mplier),
      .mcand_i   (mcand),
      .busy_o    (busy),
      .done_o    (done),
      .prod_hi_o (prod_hi),
      .prod_lo_o (prod_lo),
      .hi_zero_o (hi_zero)
   );

   // behavioural reference, advanced on every rising edge
   logic         m_busy = 1'b0, m_done = 1'b0, m_zero = 1'b1, m_ign = 1'b0;
   logic [W-1:0] m_hi = '0, m_lo = '0;
   longint unsigned m_prod = 0;
   int           m_rem = 0;
   string        tag_busy = "R2", tag_res = "R4";

   always @(posedge clk) begin
      logic prev_done;
      prev_done = m_done;
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_hi = '0; m_lo = '0; m_zero = 1; m_rem = 0;
      end else begin
         m_done = 0;
         if (m_busy) begin
            if (start) m_ign = 1;
            m_rem--;
            if (m_rem == 0) begin
               m_busy = 0;
               m_done = 1;
               m_hi   = m_prod[63:32];
               m_lo   = m_prod[31:0];
               m_zero = (m_hi == '0);
               tag_res = m_ign ? "R8" : "R4";
            end
         end else if (start) begin
            m_prod = longint'(mplier) * longint'(mcand);
            m_busy = 1;
            m_ign  = 0;
            if ((mplier | mcand) < 32'h1000) begin
               m_rem = 14; tag_busy = prev_done ? "R9" : "R2";
            end else begin
               m_rem = 34; tag_busy = prev_done ? "R9" : "R3";
            end
         end
      end
   end

   task automatic chk(input string req, input string what,
                      input longint unsigned act, input longint unsigned exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         chk(tag_busy, "busy", busy, m_busy);
         chk("R7", "done", done, m_done);
         chk(tag_res, "prod_hi", prod_hi, m_hi);
         chk(tag_res, "prod_lo", prod_lo, m_lo);
         chk("R6", "hi_zero", hi_zero, m_zero);
      end
      if (cycles > 150000) begin
         bad++; total++;
         $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic wait_done();
      while (!done) @(negedge clk);
   endtask

   task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b);
      @(negedge clk);
      while (busy || done) @(negedge clk);
      mplier = a; mcand = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      if ((a | b) < 32'h1000) chk("R5", "short hi", prod_hi, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "reset busy", busy, 0);
      chk("R1", "reset done", done, 0);
      chk("R1", "reset hi", prod_hi, 0);
      chk("R1", "reset lo", prod_lo, 0);
      chk("R1", "reset zero", hi_zero, 1);

      run_op(32'h0, 32'h0);
      run_op(32'hFFF, 32'hFFF);
      run_op(32'h1000, 32'hFFF);
      run_op(32'hFFF, 32'h1000);
      run_op(32'h8000_0000, 32'h8000_0000);
      run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF);
      run_op(32'h3, 32'h8000_0000);
      run_op(32'h8000_0000, 32'h3);
      run_op(32'hFFFF_FFFF, 32'h1);

      // R8: a start mid-run with other operands is ignored
      mplier = 32'h1234_5678; mcand = 32'h9ABC_DEF0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      mplier = 32'h7; mcand = 32'h9; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();

      // R9: start held through the done cycle launches the next run
      @(negedge clk);
      mplier = 32'hABC; mcand = 32'h123; start = 1'b1;
      wait_done();
      mplier = 32'hDEAD_BEEF; mcand = 32'hFEED_0001;
      @(negedge clk);
      start = 1'b0;
      chk("R9", "busy after done-cycle start", busy, 1);
      wait_done();

      for (int i = 0; i < 40; i++) begin
         logic [W-1:0] a, b;
         a = $urandom; b = $urandom;
         if (i % 3 == 0) begin a = a & 32'hFFF; b = b & 32'hFFF; end
         run_op(a, b);
      end

      repeat (4) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule